// File: doc/BRIEF.md
# Single-Wire Pulse-Ratio Command Receiver

This block listens on one open-drain control line and turns a train of low and high pulses into a brightness setting. A bit is not tied to any fixed bit time. Each bit is a low phase followed by a high phase, and its value comes from how long the two phases last compared with each other. The host can therefore clock bits at any rate the internal duration counters can span. A command has two bytes. An address byte comes first, then a data byte that carries an acknowledge request, a two-bit sub-address and a five-bit level. Each byte ends when the line has stayed high long enough to count as the end of a stream.

When a command names this receiver and every bit in it decoded cleanly, the block loads the level into its register and pulses a strobe. If the host set the request bit, the block then holds the line low for a fixed time as an acknowledge. The line input is expected to be already synchronised. All durations are counted in pulses of the `tick` timebase, and the `line_pull` output drives the open-drain pull-down.

Top module: `pulse_ratio_rx`

## Requirements
- R1: During reset and on the first clock after it, `level_q` is 0, `line_pull` is 0 and `level_valid` is 0. A reset applied while an acknowledge is in progress releases `line_pull` on the next clock.
- R2: Each bit starts with a falling edge and lasts until the next falling edge. It reads as 1 when its high time is at least twice its low time, and as 0 when its low time is at least twice its high time. Bits arrive MSB first. The last bit of a byte is closed by end-of-stream, which is the line staying high for EOS_TICKS; that bit's high time counts as EOS_TICKS. A frame is accepted when the first byte is 0x72, data bits 6:5 equal SUB_SEL (default 00), and every bit is clean. On acceptance, data bits 4:0 are loaded into `level_q`.
- R3: A frame whose address byte is not 0x72 leaves `level_q` unchanged, gives no strobe and gives no acknowledge.
- R4: If any bit has a ratio that is neither 1 nor 0, the whole frame is discarded: no update, no strobe, no acknowledge.
- R5: A frame whose sub-address bits differ from SUB_SEL is discarded.
- R6: When an accepted frame has data bit 7 set, `line_pull` rises ACK_DELAY_TICKS ticks after end-of-stream is detected. It stays high for exactly ACK_LEN_TICKS ticks and then falls.
- R7: An accepted frame with data bit 7 clear updates the level but never asserts `line_pull`.
- R8: A byte that ends with a bit count other than eight is dropped and does not count as the address byte, so the next complete frame is still accepted.
- R9: `level_valid` is high for exactly one clock per accepted frame, in the same clock that `level_q` takes its new value, and `level_q` does not change at any other time.
- R10: The same command sent with longer low and high phases, in the same ratios, decodes to the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe; all durations are counted in these pulses |
| line_in | input | 1 | Synchronised level of the control line |
| line_pull | output | 1 | Enables the open-drain pull-down for the acknowledge |
| level_q | output | 5 | Brightness level register |
| level_valid | output | 1 | One-clock strobe when `level_q` is loaded |

## Verification
The hardest case to reach from the ports is a frame that is correct in every way except one bit whose low and high times sit between the two 2:1 ratios. A second hard case is a final bit of 0, which only decodes if its low phase is at least twice the end-of-stream time. The bench drives the line through a host model that sets the low and high duration of every bit separately. It can plant one ambiguous bit at a chosen position in either byte, and it can switch the whole frame to a slower duration set. It resolves the open-drain line as the AND of the host and the receiver, so the acknowledge is seen on the same wire the host drives.

// File: rtl/prx_pkg.sv
// Shared constants and state types for the pulse-ratio command receiver.
// Assumes a two-byte command: address byte, then data byte.
package prx_pkg;
    localparam int BYTE_W = 8;
    localparam int LVL_W  = 5;

    typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_ACK} rx_state_t;
    typedef enum logic [1:0] {A_OFF, A_DLY, A_DRV} ack_phase_t;
endpackage

// File: rtl/prx_run_timer.sv
// Detects edges on the sampled line and measures how long the current
// phase has lasted, in timebase ticks. The count saturates at all-ones.
// Assumes line_in is already synchronised to clk.
module prx_run_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line_in,
    output logic             fall,
    output logic             rise,
    output logic [CNT_W-1:0] run_cnt
);
    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    logic             line_q;
    logic [CNT_W-1:0] run_q;

    // Edge history and phase length; on an edge the count restarts with the current tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
            run_q  <= '0;
        end else begin
            line_q <= line_in;
            if (line_q != line_in)
                run_q <= {{(CNT_W-1){1'b0}}, tick};
            else if (tick && run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    assign fall    = line_q & ~line_in;
    assign rise    = ~line_q & line_in;
    assign run_cnt = run_q;
endmodule

// File: rtl/prx_bit_judge.sv
// Classifies one bit from its low and high durations using 2:1 ratios.
// If neither output is set, the ratio is ambiguous.
module prx_bit_judge #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    output logic             is_one,
    output logic             is_zero
);
    localparam int WW = CNT_W + 1;

    logic [WW-1:0] lo_x, hi_x, lo_dbl, hi_dbl;

    // Widen both durations and compare each against twice the other.
    always_comb begin
        lo_x    = {1'b0, low_len};
        hi_x    = {1'b0, high_len};
        lo_dbl  = {low_len, 1'b0};
        hi_dbl  = {high_len, 1'b0};
        is_one  = (hi_x >= lo_dbl);
        is_zero = (lo_x >= hi_dbl);
    end
endmodule

// File: rtl/prx_ack_gen.sv
// After a start pulse, waits DLY ticks and then asserts pull for LEN ticks.
// Assumes DLY >= 1 and LEN >= 1. busy stays high from the start pulse until release.
module prx_ack_gen
    import prx_pkg::*;
#(
    parameter int TW  = 10,
    parameter int DLY = 2,
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic pull,
    output logic busy
);
    localparam logic [TW-1:0] DLY_M1 = TW'(DLY - 1);
    localparam logic [TW-1:0] LEN_M1 = TW'(LEN - 1);

    ack_phase_t    ph_q;
    logic [TW-1:0] cnt_q;

    // Steps through delay and drive phases, counting ticks in each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= A_OFF;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                A_OFF: if (start) begin
                    ph_q  <= A_DLY;
                    cnt_q <= '0;
                end
                A_DLY: if (tick) begin
                    if (cnt_q == DLY_M1) begin
                        ph_q  <= A_DRV;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                A_DRV: if (tick) begin
                    if (cnt_q == LEN_M1) ph_q  <= A_OFF;
                    else                 cnt_q <= cnt_q + 1'b1;
                end
                default: ph_q <= A_OFF;
            endcase
        end
    end

    assign pull = (ph_q == A_DRV);
    assign busy = (ph_q != A_OFF);
endmodule

// File: rtl/pulse_ratio_rx.sv
// Top level of the pulse-ratio command receiver. It frames bytes between
// start and end-of-stream, assembles the address and data bytes, qualifies
// the frame, loads the level and requests the acknowledge. Assumes the host
// keeps every high phase inside a byte shorter than EOS_TICKS.
module pulse_ratio_rx
    import prx_pkg::*;
#(
    parameter int          CNT_W           = 10,
    parameter int          START_TICKS     = 2,
    parameter int          EOS_TICKS       = 16,
    parameter int          ACK_DELAY_TICKS = 2,
    parameter int          ACK_LEN_TICKS   = 512,
    parameter logic [7:0]  DEV_ADDR        = 8'h72,
    parameter logic [1:0]  SUB_SEL         = 2'b00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             line_in,
    output logic             line_pull,
    output logic [LVL_W-1:0] level_q,
    output logic             level_valid
);
    localparam logic [CNT_W-1:0] START_C = CNT_W'(START_TICKS);
    localparam logic [CNT_W-1:0] EOS_C   = CNT_W'(EOS_TICKS);
    localparam int ACK_MAX = (ACK_LEN_TICKS > ACK_DELAY_TICKS) ? ACK_LEN_TICKS : ACK_DELAY_TICKS;
    localparam int ACK_TW  = $clog2(ACK_MAX + 1);
    localparam int PR_W    = $clog2(ACK_LEN_TICKS + 2);
    localparam logic [PR_W-1:0] PR_LIM = PR_W'(ACK_LEN_TICKS);
    localparam logic [PR_W-1:0] PR_MAX = '1;

    logic             fall, rise, is_one, is_zero, ack_busy;
    logic [CNT_W-1:0] run_cnt;

    rx_state_t           st_q;
    logic [CNT_W-1:0]    low_q;
    logic [BYTE_W-2:0]   sh_q;
    logic [3:0]          nbits_q;
    logic                byte_sel_q, addr_ok_q, bad_q;

    logic                bit_bad, eos_hit, byte_ok, frame_ok, ack_start;
    logic [BYTE_W-1:0]   byte_next;
    logic [3:0]          count_next;

    prx_run_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
        .fall(fall), .rise(rise), .run_cnt(run_cnt)
    );

    prx_bit_judge #(.CNT_W(CNT_W)) u_judge (
        .low_len(low_q), .high_len(run_cnt), .is_one(is_one), .is_zero(is_zero)
    );

    prx_ack_gen #(.TW(ACK_TW), .DLY(ACK_DELAY_TICKS), .LEN(ACK_LEN_TICKS)) u_ack (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(ack_start),
        .pull(line_pull), .busy(ack_busy)
    );

    // Decodes the pending bit and works out whether the byte and the frame qualify.
    always_comb begin
        bit_bad    = !is_one && !is_zero;
        eos_hit    = (st_q == S_HIGH) && line_in && (run_cnt >= EOS_C);
        byte_next  = {sh_q, is_one};
        count_next = nbits_q + 4'd1;
        byte_ok    = (count_next == 4'd8) && !bad_q && !bit_bad;
        frame_ok   = byte_sel_q && addr_ok_q && byte_ok && (byte_next[6:5] == SUB_SEL);
        ack_start  = eos_hit && frame_ok && byte_next[7];
    end

    // Framing state machine: start, low phase, high phase, byte close, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            low_q       <= '0;
            sh_q        <= '0;
            nbits_q     <= '0;
            byte_sel_q  <= 1'b0;
            addr_ok_q   <= 1'b0;
            bad_q       <= 1'b0;
            level_q     <= '0;
            level_valid <= 1'b0;
        end else begin
            level_valid <= 1'b0;
            case (st_q)
                S_IDLE: if (fall && run_cnt >= START_C) begin
                    st_q    <= S_LOW;
                    sh_q    <= '0;
                    nbits_q <= '0;
                    bad_q   <= 1'b0;
                end
                S_LOW: if (rise) begin
                    low_q <= run_cnt;
                    st_q  <= S_HIGH;
                end
                S_HIGH: begin
                    if (fall) begin
                        sh_q <= byte_next[BYTE_W-2:0];
                        if (nbits_q != 4'd8) nbits_q <= count_next;
                        bad_q <= bad_q | bit_bad | (nbits_q == 4'd8);
                        st_q  <= S_LOW;
                    end else if (eos_hit) begin
                        st_q <= S_IDLE;
                        if (!byte_sel_q) begin
                            if (count_next == 4'd8) begin
                                byte_sel_q <= 1'b1;
                                addr_ok_q  <= byte_ok && (byte_next == DEV_ADDR);
                            end
                        end else begin
                            byte_sel_q <= 1'b0;
                            if (frame_ok) begin
                                level_q     <= byte_next[LVL_W-1:0];
                                level_valid <= 1'b1;
                            end
                            if (ack_start) st_q <= S_ACK;
                        end
                    end
                end
                S_ACK: if (!ack_busy) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Checker aid: length of the current pull-down run, in ticks.
    logic [PR_W-1:0] pull_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !line_pull) pull_run_q <= '0;
        else if (tick && pull_run_q != PR_MAX) pull_run_q <= pull_run_q + 1'b1;
    end

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        level_valid |=> !level_valid);
    a_r9_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !level_valid |-> $stable(level_q));
    a_r2_valid_from_eos: assert property (@(posedge clk) disable iff (!rst_n)
        level_valid |-> ($past(st_q) == S_HIGH));
    a_r6_pull_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> (st_q == S_ACK));
    a_r6_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run_q <= PR_LIM);
endmodule

// File: tb/pulse_ratio_rx_tb.sv
`timescale 1ns/1ps
module pulse_ratio_rx_tb;
    localparam int EOS  = 16;
    localparam int DLY  = 2;
    localparam int LEN  = 512;
    localparam int GAP  = 24;
    localparam int OBS  = EOS + DLY + LEN + 20;
    localparam int NROW = 8;
    // Row layout: address[20:13], data[12:5], slow[4], bad bit position[3:0] (0 = none).
    localparam logic [20:0] ROWS [NROW] = '{
        {8'h72, 8'h15, 1'b0, 4'd0},
        {8'h72, 8'h8A, 1'b0, 4'd0},
        {8'h73, 8'h1F, 1'b0, 4'd0},
        {8'h72, 8'hB3, 1'b0, 4'd0},
        {8'h72, 8'h1F, 1'b1, 4'd0},
        {8'h72, 8'h80, 1'b1, 4'd0},
        {8'h72, 8'h9E, 1'b0, 4'd12},
        {8'h72, 8'h05, 1'b0, 4'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_low = 1'b0;
    logic       line_w, line_pull, level_valid;
    logic [4:0] level_q;
    int n_checks = 0, n_fail = 0, vcount = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    assign line_w = ~(host_low | line_pull);

    pulse_ratio_rx #(.EOS_TICKS(EOS), .ACK_DELAY_TICKS(DLY), .ACK_LEN_TICKS(LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(1'b1), .line_in(line_w),
        .line_pull(line_pull), .level_q(level_q), .level_valid(level_valid)
    );

    always @(negedge clk) if (level_valid) vcount++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0: return "R7";  1: return "R6";  2: return "R3";  3: return "R5";
            4: return "R10"; 5: return "R10"; default: return "R4";
        endcase
    endfunction

    // One bit: low phase, then high phase (skipped on the final bit of a byte).
    task automatic send_bit(input logic b, input bit fin, input logic slow, input bit bad);
        int l, h;
        if (bad)    begin l = 5; h = 5; end
        else if (b) begin l = slow ? 4 : 2;   h = slow ? 12 : 6; end
        else        begin l = slow ? 36 : 32; h = slow ? 3 : 2;  end
        host_low = 1'b1;
        repeat (l) @(negedge clk);
        host_low = 1'b0;
        if (!fin) repeat (h) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input logic slow,
                              input int badpos, input bit observe,
                              output int first, output int plen, output int nvalid);
        int v0;
        v0 = vcount;
        for (int i = 7; i >= 0; i--) send_bit(a[i], i == 0, slow, badpos == 8 - i);
        repeat (GAP) @(negedge clk);
        for (int i = 7; i >= 0; i--) send_bit(d[i], i == 0, slow, badpos == 16 - i);
        first = 0;
        plen  = 0;
        if (observe) begin
            for (int k = 1; k <= OBS; k++) begin
                @(negedge clk);
                if (line_pull) begin
                    if (first == 0) first = k;
                    plen++;
                end
            end
        end
        nvalid = vcount - v0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int first, plen, nv, exp_lvl;
        bit upd, eack;
        logic [7:0] a, d;
        exp_lvl = 0;
        repeat (4) @(negedge clk);
        // R1: outputs while reset is held.
        check(level_q == 5'd0, "R1 level in reset", level_q, 0);
        check(line_pull == 1'b0, "R1 pull in reset", line_pull, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(level_valid == 1'b0, "R1 strobe after reset", level_valid, 0);
        repeat (10) @(negedge clk);

        // Table walk: R2..R7, R9, R10.
        for (int i = 0; i < NROW; i++) begin
            a = ROWS[i][20:13];
            d = ROWS[i][12:5];
            upd  = (a == 8'h72) && (d[6:5] == 2'b00) && (ROWS[i][3:0] == 4'd0);
            eack = upd && d[7];
            send_frame(a, d, ROWS[i][4], int'(ROWS[i][3:0]), 1'b1, first, plen, nv);
            if (upd) exp_lvl = int'(d[4:0]);
            check(int'(level_q) == exp_lvl, upd ? "R2 level" : row_tag(i), level_q, exp_lvl);
            check(nv == (upd ? 1 : 0), "R9 strobe count", nv, upd ? 1 : 0);
            check(first == (eack ? EOS + DLY + 1 : 0), eack ? "R6 ack start" : "R7 no ack",
                  first, eack ? EOS + DLY + 1 : 0);
            check(plen == (eack ? LEN : 0), eack ? "R6 ack length" : "R7 ack length",
                  plen, eack ? LEN : 0);
        end

        // R8: a 3-bit burst is dropped and the next frame is still accepted.
        send_bit(1'b1, 1'b0, 1'b0, 1'b0);
        send_bit(1'b0, 1'b0, 1'b0, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        check(int'(level_q) == exp_lvl, "R8 burst ignored", level_q, exp_lvl);
        send_frame(8'h72, 8'h0C, 1'b0, 0, 1'b1, first, plen, nv);
        check(level_q == 5'd12, "R8 resync level", level_q, 12);
        check(nv == 1, "R8 resync strobe", nv, 1);

        // R1: reset during an acknowledge releases the line.
        send_frame(8'h72, 8'h81, 1'b0, 0, 1'b0, first, plen, nv);
        repeat (EOS + DLY + 5) @(negedge clk);
        check(line_pull == 1'b1, "R6 ack active before reset", line_pull, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(line_pull == 1'b0, "R1 pull released by reset", line_pull, 0);
        check(level_q == 5'd0, "R1 level cleared by reset", level_q, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule